// File: doc/BRIEF.md
# Self-Triggered Parallel-to-Serial Exchange Master

This block reduces pin count. It takes a word from a wide set of parallel input signals, or from a set of register bits, and sends it as a serial frame on an SPI-style link. It drives the serial clock and an active-low chip select as master. In the same frame it collects the bits coming back from the far end. It then presents the received word on a set of parallel output pins and in a readable data register.

No processor writes are needed frame by frame. The block decides by itself when to send. In continuous mode it starts a new frame each time the mandatory idle gap has passed. In change mode it sends only when the selected source word, masked to the frame length, differs from the word it last sent. The frame length can be set from 4 to the parameter `MAX_W` (32 by default). The serial clock runs at the system clock divided by the even parameter `CLK_DIV`. The serial clock and chip select may be shared with other devices, so chip select is released between frames.

Top module: `dsi_master`

## Requirements
- R1: The number of serial clock pulses in a frame equals `frame_len`. A value below 4 is treated as 4, and a value above `MAX_W` is treated as `MAX_W`. The length is taken when the frame starts.
- R2: The frame carries bits `len-1` down to 0 of the source word, most significant first. Source bits at or above `len` have no effect on the frame and do not trigger one.
- R3: `src_sel` = 0 selects `par_in` as the source word, and `src_sel` = 1 selects `reg_bits`.
- R4: At the end of a frame, `par_out` and `rx_data` both hold the received bits, right-aligned. The first bit received becomes bit `len-1`, and every bit at or above `len` is 0.
- R5: `par_out` and `rx_data` change only on the clock edge that releases chip select at the end of a frame. Both are 0 after reset.
- R6: With `trig_mode` = 0 (continuous), a new frame starts exactly `CLK_DIV` cycles after the previous frame ends.
- R7: With `trig_mode` = 1 (change), a frame starts only when the masked source word differs from the last word sent. The last word sent is 0 after reset.
- R8: While `en` is 0, no frame starts. A frame already running finishes at its full length.
- R9: Between frames `cs_n` is 1 and `sck` is 0, and `cs_n` stays high for at least `CLK_DIV` cycles before each frame, including the first one after reset.
- R10: `sck` idles low and each half period lasts `CLK_DIV/2` cycles. `mosi` changes only on a rising `sck` edge, and `miso` is sampled on the falling `sck` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Allows new frames to start |
| trig_mode | input | 1 | 0 = continuous, 1 = start on change |
| src_sel | input | 1 | 0 = parallel inputs, 1 = register bits |
| frame_len | input | $clog2(MAX_W+1) | Requested frame length in bits |
| par_in | input | MAX_W | Parallel input signals |
| reg_bits | input | MAX_W | Register-sourced word |
| miso | input | 1 | Serial data from the far end |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the far end |
| par_out | output | MAX_W | Parallel output pins holding the last received word |
| rx_data | output | MAX_W | Data register holding the last received word |

## Verification
The checks assume that `en` is sampled only on system clock edges, and that `miso` is settled well before the falling `sck` edge at which it is sampled. The bench meets both conditions. It drives every control input on the falling system clock edge and changes `miso` right after each rising `sck`, which leaves half a serial period of setup time. The bench also keeps `frame_len` and the source word steady for the whole of a frame. In continuous mode it drops `en` right after a frame that it has observed, so that no frame passes unobserved and the expected last-sent word and received word stay in step with the design.

// File: rtl/dsi_pkg.sv
// Package: shared types and constants for the parallel-to-serial master.
// Assumes: nothing beyond IEEE 1800-2017.
package dsi_pkg;

    // Trigger policy selected by the trig_mode pin
    typedef enum logic {
        TRIG_CONT   = 1'b0,
        TRIG_CHANGE = 1'b1
    } trig_mode_e;

    // Shortest frame the engine accepts
    localparam int MIN_LEN = 4;

endpackage

// File: rtl/dsi_sck_gen.sv
// Module: serial clock generator.
// Produces sck with a half period of CLK_DIV/2 system cycles while run is
// high, and one-cycle rise/fall ticks on the cycle that toggles sck.
// Assumes: CLK_DIV is even and at least 2; run drops on a fall tick.
module dsi_sck_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = CLK_DIV / 2;

    logic tick;

    generate
        if (HALF == 1) begin : g_fast
            // Every running cycle toggles the clock
            assign tick = run;
        end else begin : g_div
            localparam int PH_W = $clog2(HALF);
            logic [PH_W-1:0] ph_q;

            // Phase counter across one half period
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    ph_q <= '0;
                end else if (ph_q == PH_W'(HALF - 1)) begin
                    ph_q <= '0;
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end

            assign tick = run && (ph_q == PH_W'(HALF - 1));
        end
    endgenerate

    assign rise_tick = tick && !sck;
    assign fall_tick = tick && sck;

    // Serial clock register, idles low
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sck <= 1'b0;
        end else if (tick) begin
            sck <= ~sck;
        end
    end

endmodule

// File: rtl/dsi_trigger.sv
// Module: start decision.
// Issues a one-cycle start when the engine is ready and the enable and the
// selected trigger policy allow it; remembers the last word sent.
// Assumes: cur_word is already masked to the frame length.
module dsi_trigger
    import dsi_pkg::*;
#(
    parameter int MAX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  trig_mode_e       mode,
    input  logic             ready,
    input  logic [MAX_W-1:0] cur_word,
    output logic             start
);
    logic [MAX_W-1:0] last_q;
    logic             want;

    // Policy: continuous always wants, change mode wants on difference
    always_comb begin
        unique case (mode)
            TRIG_CONT:   want = 1'b1;
            TRIG_CHANGE: want = (cur_word != last_q);
            default:     want = 1'b0;
        endcase
    end

    assign start = ready && en && want;

    // Record the word carried by each started frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (start) begin
            last_q <= cur_word;
        end
    end

endmodule

// File: rtl/dsi_shift_engine.sv
// Module: frame shift engine.
// Owns chip select, the transmit and receive shift registers, the bit count,
// the output latch and the idle gap between frames.
// Assumes: start only arrives while ready; ticks come from dsi_sck_gen.
module dsi_shift_engine #(
    parameter int MAX_W   = 32,
    parameter int CLK_DIV = 4,
    parameter int LEN_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [MAX_W-1:0] load_word,
    input  logic [LEN_W-1:0] load_len,
    input  logic             rise_tick,
    input  logic             fall_tick,
    input  logic             miso,
    output logic             busy,
    output logic             ready,
    output logic             cs_n,
    output logic             mosi,
    output logic [MAX_W-1:0] rx_word
);
    localparam int               GAP_W   = $clog2(CLK_DIV + 1);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_W);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(CLK_DIV - 1);

    logic [MAX_W-1:0] tx_sh;
    logic [MAX_W-1:0] rx_sh;
    logic [MAX_W-1:0] rx_next;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] bit_cnt;
    logic [GAP_W-1:0] gap_q;
    logic             last_bit;

    assign rx_next  = {rx_sh[MAX_W-2:0], miso};
    assign last_bit = (bit_cnt == len_q - 1'b1);
    assign ready    = !busy && (gap_q == '0);

    // Frame control: chip select, busy flag and gap count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cs_n  <= 1'b1;
            gap_q <= GAP_MAX;
        end else if (start) begin
            busy <= 1'b1;
            cs_n <= 1'b0;
        end else if (busy && fall_tick && last_bit) begin
            busy  <= 1'b0;
            cs_n  <= 1'b1;
            gap_q <= GAP_MAX;
        end else if (!busy && gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    // Transmit path: left-align on start, present next bit on rising sck
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            mosi  <= 1'b0;
        end else if (start) begin
            tx_sh <= load_word << (MAX_LEN - load_len);
        end else if (busy && rise_tick) begin
            mosi  <= tx_sh[MAX_W-1];
            tx_sh <= {tx_sh[MAX_W-2:0], 1'b0};
        end
    end

    // Receive path: clear on start, sample miso on falling sck
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            bit_cnt <= '0;
            len_q   <= LEN_W'(4);
        end else if (start) begin
            rx_sh   <= '0;
            bit_cnt <= '0;
            len_q   <= load_len;
        end else if (busy && fall_tick) begin
            rx_sh   <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Output latch: updates once per completed frame, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (busy && fall_tick && last_bit) begin
            rx_word <= rx_next;
        end
    end

endmodule

// File: rtl/dsi_master.sv
// Module: self-triggered parallel-to-serial exchange master (top).
// Selects and masks the source word, clamps the frame length, and ties the
// trigger, clock generator and shift engine together.
// Assumes: CLK_DIV even and >= 2, MAX_W >= 4; inputs synchronous to clk.
module dsi_master
    import dsi_pkg::*;
#(
    parameter int MAX_W   = 32,
    parameter int CLK_DIV = 4,
    parameter int LEN_W   = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             trig_mode,
    input  logic             src_sel,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [MAX_W-1:0] par_in,
    input  logic [MAX_W-1:0] reg_bits,
    input  logic             miso,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    output logic [MAX_W-1:0] par_out,
    output logic [MAX_W-1:0] rx_data
);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_W);

    logic [LEN_W-1:0] len_c;
    logic [MAX_W-1:0] mask;
    logic [MAX_W-1:0] word;
    logic             start;
    logic             busy;
    logic             ready;
    logic             rise_tick;
    logic             fall_tick;
    logic [MAX_W-1:0] rx_word;
    trig_mode_e       mode;

    // Clamp the requested length into the supported range
    always_comb begin
        if (frame_len < MIN_L) begin
            len_c = MIN_L;
        end else if (frame_len > MAX_L) begin
            len_c = MAX_L;
        end else begin
            len_c = frame_len;
        end
    end

    // Source selection and masking to the frame length
    assign mask = ~({MAX_W{1'b1}} << len_c);
    assign word = (src_sel ? reg_bits : par_in) & mask;
    assign mode = trig_mode_e'(trig_mode);

    dsi_trigger #(
        .MAX_W(MAX_W)
    ) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .mode    (mode),
        .ready   (ready),
        .cur_word(word),
        .start   (start)
    );

    dsi_sck_gen #(
        .CLK_DIV(CLK_DIV)
    ) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .sck      (sck),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick)
    );

    dsi_shift_engine #(
        .MAX_W  (MAX_W),
        .CLK_DIV(CLK_DIV),
        .LEN_W  (LEN_W)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load_word(word),
        .load_len (len_c),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick),
        .miso     (miso),
        .busy     (busy),
        .ready    (ready),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .rx_word  (rx_word)
    );

    // Pins and data register both show the latched word
    assign par_out = rx_word;
    assign rx_data = rx_word;

endmodule

// File: rtl/dsi_master_chk.sv
// Module: protocol checker bound to dsi_master.
// Assumes: en is sampled on clk; observes ports only.
module dsi_master_chk #(
    parameter int MAX_W   = 32,
    parameter int CLK_DIV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             sck,
    input logic             cs_n,
    input logic             mosi,
    input logic [MAX_W-1:0] par_out,
    input logic [MAX_W-1:0] rx_data
);
    logic [15:0] hi_cnt;

    // Count consecutive cycles with chip select released, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != 16'hFFFF) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= 16'(CLK_DIV)));

    a_r9_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    a_r10_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$rose(sck)) |-> $stable(mosi));

    a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(cs_n) |-> ($stable(par_out) && $stable(rx_data)));

    a_r8_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && cs_n) |=> cs_n);

endmodule

bind dsi_master dsi_master_chk #(
    .MAX_W  (MAX_W),
    .CLK_DIV(CLK_DIV)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .sck    (sck),
    .cs_n   (cs_n),
    .mosi   (mosi),
    .par_out(par_out),
    .rx_data(rx_data)
);

// File: tb/sim_dsi_master.sv
module sim_dsi_master;
    localparam int MAX_W   = 32;
    localparam int CLK_DIV = 4;
    localparam int LEN_W   = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             trig_mode = 1'b0;
    logic             src_sel = 1'b0;
    logic [LEN_W-1:0] frame_len = 6'd8;
    logic [MAX_W-1:0] par_in = '0;
    logic [MAX_W-1:0] reg_bits = '0;
    logic             miso = 1'b0;
    logic             sck;
    logic             cs_n;
    logic             mosi;
    logic [MAX_W-1:0] par_out;
    logic [MAX_W-1:0] rx_data;

    int n_chk = 0;
    int n_err = 0;
    int nfall = 0;
    logic [31:0] prev_rx = '0;

    dsi_master #(.MAX_W(MAX_W), .CLK_DIV(CLK_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .trig_mode(trig_mode),
        .src_sel(src_sel), .frame_len(frame_len), .par_in(par_in),
        .reg_bits(reg_bits), .miso(miso), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .par_out(par_out), .rx_data(rx_data)
    );

    always #10 clk = ~clk;

    always @(negedge cs_n) nfall++;

    function automatic int clamp_len(input int l);
        if (l < 4) return 4;
        if (l > MAX_W) return MAX_W;
        return l;
    endfunction

    function automatic logic [31:0] mask_of(input int l);
        return (l >= 32) ? 32'hFFFF_FFFF : ((32'h1 << l) - 32'h1);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Drop enable on a falling clock edge and wait out any running frame
    task automatic quiesce();
        @(negedge clk);
        en = 1'b0;
        while (!cs_n) cycles(1);
        cycles(2);
    endtask

    // Observe one frame as the far end; check length, data and latch
    task automatic run_frame(input int len, input logic [31:0] src,
                             input string tag, input bit drop_en);
        int t = 0;
        logic [31:0] mpat;
        logic [31:0] got = '0;
        while (cs_n && t < 3000) begin
            cycles(1);
            t++;
        end
        check(!cs_n, "R6", {tag, " frame start"}, 32'(cs_n), 32'd0);
        if (cs_n) return;
        if (drop_en) begin
            @(negedge clk);
            en = 1'b0;
        end
        mpat = $urandom;
        for (int k = 0; k < len; k++) begin
            @(posedge sck);
            miso = mpat[len-1-k];
            @(negedge sck);
            #1;
            got = {got[30:0], mosi};
            if (k < len - 1 && cs_n) begin
                check(1'b0, "R1", {tag, " early end"}, 32'(k), 32'(len));
                return;
            end
            if (k == 1)
                check(par_out == prev_rx, "R5", {tag, " hold mid-frame"},
                      par_out, prev_rx);
        end
        check(cs_n == 1'b1, "R1", {tag, " end after len bits"},
              32'(cs_n), 32'd1);
        check(got == (src & mask_of(len)), "R2", {tag, " mosi word"},
              got, src & mask_of(len));
        check(par_out == (mpat & mask_of(len)), "R4", {tag, " par_out"},
              par_out, mpat & mask_of(len));
        check(rx_data == (mpat & mask_of(len)), "R4", {tag, " rx_data"},
              rx_data, mpat & mask_of(len));
        prev_rx = mpat & mask_of(len);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int n0;
        int gap;
        void'($urandom(32'd1234));
        cycles(4);
        check(cs_n == 1'b1 && sck == 1'b0, "R9", "reset idle",
              {30'd0, cs_n, sck}, 32'd2);
        check(par_out == '0 && rx_data == '0, "R5", "reset outputs",
              par_out | rx_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: disabled, nothing starts
        cycles(200);
        check(nfall == 0, "R8", "disabled idle", 32'(nfall), 32'd0);

        // R6: continuous, back-to-back frames and exact gap
        @(negedge clk);
        par_in = 32'hFFFF_FFA5; frame_len = 6'd8; en = 1'b1;
        run_frame(8, par_in, "cont1", 1'b0);
        gap = 0;
        while (cs_n && gap < 100) begin
            cycles(1);
            gap++;
        end
        check(gap == CLK_DIV, "R6", "gap cycles", 32'(gap), 32'(CLK_DIV));
        run_frame(8, par_in, "cont2", 1'b0);
        quiesce();

        // R3: register bits as source
        @(negedge clk);
        src_sel = 1'b1; reg_bits = 32'h1234_5678; par_in = 32'h0000_9999;
        frame_len = 6'd16; en = 1'b1;
        run_frame(16, reg_bits, "R3 regsrc", 1'b0);
        quiesce();

        // R1: length clamping at both ends and the full length
        @(negedge clk);
        src_sel = 1'b0; par_in = 32'hC3C3_C3C3; frame_len = 6'd2; en = 1'b1;
        run_frame(4, par_in, "R1 short", 1'b0);
        quiesce();
        @(negedge clk);
        frame_len = 6'd40; par_in = 32'h8765_4321; en = 1'b1;
        run_frame(32, par_in, "R1 long", 1'b0);
        quiesce();
        @(negedge clk);
        frame_len = 6'd32; par_in = 32'h0F1E_2D3C; en = 1'b1;
        run_frame(32, par_in, "R1 full", 1'b0);
        quiesce();

        // R7: change-triggered operation
        @(negedge clk);
        trig_mode = 1'b1; frame_len = 6'd12;
        par_in = 32'h0F1E_2D3C ^ 32'h0000_0ABC; en = 1'b1;
        run_frame(12, par_in, "R7 first", 1'b0);
        n0 = nfall;
        cycles(150);
        check(nfall == n0, "R7", "no change no frame", 32'(nfall), 32'(n0));
        @(negedge clk);
        par_in = par_in ^ 32'hFFFF_F000;
        cycles(150);
        check(nfall == n0, "R2", "upper bits no trigger", 32'(nfall), 32'(n0));
        @(negedge clk);
        par_in = par_in ^ 32'h0000_0001;
        run_frame(12, par_in, "R7 changed", 1'b0);
        quiesce();

        // R8: dropping enable mid-frame lets it finish, then nothing starts
        @(negedge clk);
        trig_mode = 1'b0; frame_len = 6'd10; par_in = 32'h0000_02D7; en = 1'b1;
        run_frame(10, par_in, "R8 drop", 1'b1);
        n0 = nfall;
        cycles(100);
        check(nfall == n0, "R8", "no start after drop", 32'(nfall), 32'(n0));

        // Random frames over length, source and data (R1 R2 R3 R4)
        for (int i = 0; i < 14; i++) begin
            int l;
            l = 1 + int'($urandom % 40);
            @(negedge clk);
            src_sel = 1'($urandom);
            par_in = $urandom;
            reg_bits = $urandom;
            frame_len = 6'(l);
            en = 1'b1;
            run_frame(clamp_len(l), src_sel ? reg_bits : par_in, "random", 1'b0);
            quiesce();
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule